// File: doc/BRIEF.md
# Dual-Port Semaphore Latch Bank

This block holds a bank of hardware semaphores that two independent agents, a left port and a right port, use to claim shared resources. The bank sits beside a shared memory but does not hold memory data. Each port has its own semaphore select, chip enable, address, write strobe, output enable, write data and read data. A port claims a semaphore by writing 0 to bit 0 and gives it back by writing 1. Reading returns that port's own view: 0 means "this port owns it" and 1 means "free or owned by the other side".

Both ports may hit the same semaphore in the same clock cycle. A tie on a free semaphore goes to the left port. If the losing side asks for a semaphore while it is held, that request waits and is granted in the same cycle that the owner releases. Read data passes through a per-port output register. A read therefore shows the state before any write in that cycle, and the value then stays fixed until that port reads again.

Top module: `sem_bank`

## Requirements
- R1: After reset every semaphore is free with no waiting request, so a read from either port returns all ones. Both read registers reset to all ones.
- R2: A port accesses the bank only in a cycle where its select is 0 and its chip enable is 1. Only the low three address bits choose the semaphore; the remaining address bits have no effect.
- R3: A write of 0 (data bit 0) to a free semaphore makes the writing port its owner. That port then reads 0 and the other port reads 1. Data bits above bit 0 are ignored on writes.
- R4: While one port owns a semaphore, no write from the other port changes either port's view of it.
- R5: When the owner writes 1 and no request is waiting, the semaphore becomes free and both ports read 1.
- R6: If the non-owner wrote 0 while the semaphore was held, that port becomes owner in the same cycle the owner writes 1. A 0 written by the non-owner in the release cycle itself also takes ownership.
- R7: If both ports write 0 to the same free semaphore in one cycle, the left port wins and the right port's request is kept as waiting.
- R8: A non-owner writing 1 withdraws its own waiting request; otherwise it has no effect.
- R9: A read (write strobe 1, output enable 0) loads that port's read register one cycle later. The value is the port's view of the addressed semaphore copied onto every data bit, taken before any write in the same cycle.
- R10: A port's read register keeps its value in every cycle in which that port does not read, even when the semaphore changes.
- R11: A cycle with the write strobe at 1 and output enable at 1 neither reads nor writes. Output enable has no effect on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_ce_n | input | 1 | Left memory chip enable; must be 1 for a semaphore access |
| l_addr | input | ADDR_W | Left address; low three bits pick the semaphore |
| l_we_n | input | 1 | Left write strobe, 0 writes |
| l_oe_n | input | 1 | Left output enable, 0 enables a read |
| l_wdata | input | DATA_W | Left write data; only bit 0 used |
| l_rdata | output | DATA_W | Left registered read data |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_ce_n | input | 1 | Right memory chip enable; must be 1 for a semaphore access |
| r_addr | input | ADDR_W | Right address; low three bits pick the semaphore |
| r_we_n | input | 1 | Right write strobe, 0 writes |
| r_oe_n | input | 1 | Right output enable, 0 enables a read |
| r_wdata | input | DATA_W | Right write data; only bit 0 used |
| r_rdata | output | DATA_W | Right registered read data |

## Verification
Some rules are checked on every cycle by the assertions. An owner keeps its semaphore unless it writes 1. A free semaphore goes to the sole requester, or to the left port on a tie. Read data always has all bits equal. A read register never moves in a cycle without a read. Some behaviour depends on hidden waiting requests, so only the bench scenarios can show it: the handoff on release, the withdrawal of a waiting request, and the fact that a same-cycle read sees the state from before the write. The bench scenarios also cover address-bit masking and the enable and output-enable qualifiers.

// File: rtl/sem_pkg.sv
package sem_pkg;
    typedef enum logic [1:0] {
        OWN_FREE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } own_e;
endpackage

// File: rtl/sem_port_dec.sv
module sem_port_dec #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 12,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input  logic               sel_n,
    input  logic               ce_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               we_n,
    input  logic               oe_n,
    output logic [NUM_SEM-1:0] wr_hit,
    output logic               rd_en,
    output logic [IDX_W-1:0]   rd_idx
);
    logic             access;
    logic [IDX_W-1:0] idx;

    always_comb begin
        access = !sel_n && ce_n;
        idx    = addr[IDX_W-1:0];
        wr_hit = (access && !we_n) ? (NUM_SEM'(1) << idx) : '0;
        rd_en  = access && we_n && !oe_n;
        rd_idx = idx;
    end
endmodule

// File: rtl/sem_cell.sv
module sem_cell
    import sem_pkg::*;
(
    input  own_e own_q,
    input  logic pend_q,
    input  logic l_wr,
    input  logic l_bit,
    input  logic r_wr,
    input  logic r_bit,
    output own_e own_d,
    output logic pend_d,
    output logic l_view,
    output logic r_view
);
    logic l_req, l_rel, r_req, r_rel;

    always_comb begin
        l_req  = l_wr && !l_bit;
        l_rel  = l_wr &&  l_bit;
        r_req  = r_wr && !r_bit;
        r_rel  = r_wr &&  r_bit;
        own_d  = own_q;
        pend_d = pend_q;
        unique case (own_q)
            OWN_LEFT: begin
                if (l_rel) begin
                    pend_d = 1'b0;
                    own_d  = (r_req || (pend_q && !r_rel)) ? OWN_RIGHT : OWN_FREE;
                end else if (r_req) begin
                    pend_d = 1'b1;
                end else if (r_rel) begin
                    pend_d = 1'b0;
                end
            end
            OWN_RIGHT: begin
                if (r_rel) begin
                    pend_d = 1'b0;
                    own_d  = (l_req || (pend_q && !l_rel)) ? OWN_LEFT : OWN_FREE;
                end else if (l_req) begin
                    pend_d = 1'b1;
                end else if (l_rel) begin
                    pend_d = 1'b0;
                end
            end
            default: begin
                pend_d = 1'b0;
                if (l_req) begin
                    own_d  = OWN_LEFT;
                    pend_d = r_req;
                end else if (r_req) begin
                    own_d  = OWN_RIGHT;
                end else begin
                    own_d  = OWN_FREE;
                end
            end
        endcase
        l_view = (own_q != OWN_LEFT);
        r_view = (own_q != OWN_RIGHT);
    end
endmodule

// File: rtl/sem_bank.sv
module sem_bank
    import sem_pkg::*;
#(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_sel_n,
    input  logic              l_ce_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_we_n,
    input  logic              l_oe_n,
    input  logic [DATA_W-1:0] l_wdata,
    output logic [DATA_W-1:0] l_rdata,
    input  logic              r_sel_n,
    input  logic              r_ce_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_we_n,
    input  logic              r_oe_n,
    input  logic [DATA_W-1:0] r_wdata,
    output logic [DATA_W-1:0] r_rdata
);
    localparam int IDX_W = $clog2(NUM_SEM);

    typedef struct packed {
        own_e [NUM_SEM-1:0] own;
        logic [NUM_SEM-1:0] pend;
        logic [DATA_W-1:0]  l_rd;
        logic [DATA_W-1:0]  r_rd;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_SEM-1:0] l_hit, r_hit;
    logic               l_rd_en, r_rd_en;
    logic [IDX_W-1:0]   l_rd_idx, r_rd_idx;
    logic [NUM_SEM-1:0] l_view, r_view;
    own_e [NUM_SEM-1:0] own_nx;
    logic [NUM_SEM-1:0] pend_nx;

    sem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_dec_l (
        .sel_n(l_sel_n), .ce_n(l_ce_n), .addr(l_addr), .we_n(l_we_n), .oe_n(l_oe_n),
        .wr_hit(l_hit), .rd_en(l_rd_en), .rd_idx(l_rd_idx)
    );

    sem_port_dec #(.NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W)) u_dec_r (
        .sel_n(r_sel_n), .ce_n(r_ce_n), .addr(r_addr), .we_n(r_we_n), .oe_n(r_oe_n),
        .wr_hit(r_hit), .rd_en(r_rd_en), .rd_idx(r_rd_idx)
    );

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
        sem_cell u_cell (
            .own_q (st_q.own[i]),
            .pend_q(st_q.pend[i]),
            .l_wr  (l_hit[i]),
            .l_bit (l_wdata[0]),
            .r_wr  (r_hit[i]),
            .r_bit (r_wdata[0]),
            .own_d (own_nx[i]),
            .pend_d(pend_nx[i]),
            .l_view(l_view[i]),
            .r_view(r_view[i])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.own  = own_nx;
        st_d.pend = pend_nx;
        if (l_rd_en) st_d.l_rd = {DATA_W{l_view[l_rd_idx]}};
        if (r_rd_en) st_d.r_rd = {DATA_W{r_view[r_rd_idx]}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.own  <= {NUM_SEM{OWN_FREE}};
            st_q.pend <= '0;
            st_q.l_rd <= '1;
            st_q.r_rd <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign l_rdata = st_q.l_rd;
    assign r_rdata = st_q.r_rd;
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
    parameter int NUM_SEM = 8,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 8,
    localparam int IDX_W  = $clog2(NUM_SEM)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               l_sel_n,
    input logic               l_ce_n,
    input logic [ADDR_W-1:0]  l_addr,
    input logic               l_we_n,
    input logic               l_oe_n,
    input logic [DATA_W-1:0]  l_wdata,
    input logic [DATA_W-1:0]  l_rdata,
    input logic               r_sel_n,
    input logic               r_ce_n,
    input logic [ADDR_W-1:0]  r_addr,
    input logic               r_we_n,
    input logic               r_oe_n,
    input logic [DATA_W-1:0]  r_wdata,
    input logic [DATA_W-1:0]  r_rdata,
    input logic [NUM_SEM-1:0] l_view,
    input logic [NUM_SEM-1:0] r_view
);
    logic l_acc, r_acc, l_rd, r_rd;
    assign l_acc = !l_sel_n && l_ce_n;
    assign r_acc = !r_sel_n && r_ce_n;
    assign l_rd  = l_acc && l_we_n && !l_oe_n;
    assign r_rd  = r_acc && r_we_n && !r_oe_n;

    // R9: every data bit carries the same value
    p_all_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(l_rdata) == 0 || $countones(l_rdata) == DATA_W) &&
        ($countones(r_rdata) == 0 || $countones(r_rdata) == DATA_W));

    // R10: no read, no change
    p_l_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !l_rd |=> $stable(l_rdata));
    p_r_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !r_rd |=> $stable(r_rdata));

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
        logic l_w, r_w;
        assign l_w = l_acc && !l_we_n && (l_addr[IDX_W-1:0] == IDX_W'(i));
        assign r_w = r_acc && !r_we_n && (r_addr[IDX_W-1:0] == IDX_W'(i));

        p_l_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !l_view[i] && !(l_w && l_wdata[0]) |=> !l_view[i]);
        p_r_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !r_view[i] && !(r_w && r_wdata[0]) |=> !r_view[i]);
        p_l_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
            l_view[i] && r_view[i] && l_w && !l_wdata[0] |=> !l_view[i] && r_view[i]);
        p_r_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
            l_view[i] && r_view[i] && r_w && !r_wdata[0] && !(l_w && !l_wdata[0])
            |=> !r_view[i] && l_view[i]);
        p_tie_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
            l_view[i] && r_view[i] && l_w && !l_wdata[0] && r_w && !r_wdata[0]
            |=> !l_view[i]);
    end
endmodule

bind sem_bank sem_bank_chk #(
    .NUM_SEM(NUM_SEM), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_ce_n(l_ce_n), .l_addr(l_addr), .l_we_n(l_we_n),
    .l_oe_n(l_oe_n), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel_n(r_sel_n), .r_ce_n(r_ce_n), .r_addr(r_addr), .r_we_n(r_we_n),
    .r_oe_n(r_oe_n), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .l_view(l_view), .r_view(r_view)
);

// File: tb/sem_bank_tb.sv
module sem_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int DW = 8;
    localparam logic [DW-1:0] ONES  = '1;
    localparam logic [DW-1:0] ZEROS = '0;

    typedef struct packed {
        logic          sel_n;
        logic          ce_n;
        logic [AW-1:0] addr;
        logic          we_n;
        logic          oe_n;
        logic [DW-1:0] wd;
    } pins_t;

    typedef struct {
        bit            right;
        logic [DW-1:0] exp;
        string         tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    pins_t lp, rp;
    logic [DW-1:0] l_rdata, r_rdata;
    int checks = 0;
    int errors = 0;
    item_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_bank #(.NUM_SEM(8), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_sel_n(lp.sel_n), .l_ce_n(lp.ce_n), .l_addr(lp.addr), .l_we_n(lp.we_n),
        .l_oe_n(lp.oe_n), .l_wdata(lp.wd), .l_rdata(l_rdata),
        .r_sel_n(rp.sel_n), .r_ce_n(rp.ce_n), .r_addr(rp.addr), .r_we_n(rp.we_n),
        .r_oe_n(rp.oe_n), .r_wdata(rp.wd), .r_rdata(r_rdata)
    );

    function automatic pins_t IDLE();
        return '{sel_n: 1'b1, ce_n: 1'b1, addr: '0, we_n: 1'b1, oe_n: 1'b1, wd: '0};
    endfunction
    function automatic pins_t WR(input logic [AW-1:0] a, input logic [DW-1:0] d);
        return '{sel_n: 1'b0, ce_n: 1'b1, addr: a, we_n: 1'b0, oe_n: 1'b1, wd: d};
    endfunction
    function automatic pins_t RD(input logic [AW-1:0] a);
        return '{sel_n: 1'b0, ce_n: 1'b1, addr: a, we_n: 1'b1, oe_n: 1'b0, wd: '0};
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // driver: one cycle of pins
    task automatic cyc(input pins_t l, input pins_t r);
        @(negedge clk);
        lp = l;
        rp = r;
        @(posedge clk);
        #1;
    endtask

    task automatic push(input bit right, input logic [DW-1:0] exp, input string tag);
        item_t it;
        it.right = right;
        it.exp   = exp;
        it.tag   = tag;
        sb.push_back(it);
    endtask

    task automatic rd_l(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        cyc(RD(a), IDLE());
        push(1'b0, exp, tag);
    endtask
    task automatic rd_r(input logic [AW-1:0] a, input logic [DW-1:0] exp, input string tag);
        cyc(IDLE(), RD(a));
        push(1'b1, exp, tag);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, it.right ? r_rdata : l_rdata, it.exp);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        lp = IDLE();
        rp = IDLE();
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset left rdata", l_rdata, ONES);
        check("R1 reset right rdata", r_rdata, ONES);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 8; i++) begin
            rd_l(AW'(i), ONES, "R1 left free after reset");
            rd_r(AW'(i), ONES, "R1 right free after reset");
        end

        // R3: claim with upper data bits set
        cyc(WR(12'd2, 8'hFE), IDLE());
        rd_l(12'd2, ZEROS, "R3 left owns sem2");
        rd_r(12'd2, ONES, "R3 right sees sem2 taken");

        // R2: select inactive, chip enable active, upper address bits
        cyc('{sel_n: 1'b1, ce_n: 1'b1, addr: 12'd5, we_n: 1'b0, oe_n: 1'b1, wd: 8'h00}, IDLE());
        rd_l(12'd5, ONES, "R2 no access without select");
        cyc('{sel_n: 1'b0, ce_n: 1'b0, addr: 12'd5, we_n: 1'b0, oe_n: 1'b1, wd: 8'h00}, IDLE());
        rd_l(12'd5, ONES, "R2 no access with chip enable low");
        cyc(WR(12'hA85, 8'h00), IDLE());
        rd_l(12'h005, ZEROS, "R2 upper address bits ignored");
        cyc(WR(12'h005, 8'h01), IDLE());

        // R4: non-owner writes do nothing visible
        cyc(IDLE(), WR(12'd2, 8'h01));
        rd_r(12'd2, ONES, "R4 right write 1 no effect");
        rd_l(12'd2, ZEROS, "R4 left still owns");
        cyc(IDLE(), WR(12'd2, 8'h00));
        rd_l(12'd2, ZEROS, "R4 left keeps after right request");
        rd_r(12'd2, ONES, "R4 right still waiting");

        // R6: handoff on release
        cyc(WR(12'd2, 8'h01), IDLE());
        rd_r(12'd2, ZEROS, "R6 right gets sem2 on release");
        rd_l(12'd2, ONES, "R6 left lost sem2");
        // R5: release to free
        cyc(IDLE(), WR(12'd2, 8'h01));
        rd_l(12'd2, ONES, "R5 left sees free");
        rd_r(12'd2, ONES, "R5 right sees free");

        // R7: tie to left, right waits
        cyc(WR(12'd6, 8'h00), WR(12'd6, 8'h00));
        rd_l(12'd6, ZEROS, "R7 left wins tie");
        rd_r(12'd6, ONES, "R7 right loses tie");
        cyc(WR(12'd6, 8'h01), IDLE());
        rd_r(12'd6, ZEROS, "R7 right tie request kept");
        cyc(IDLE(), WR(12'd6, 8'h01));
        rd_l(12'd6, ONES, "R5 sem6 free again");

        // R6: request in the release cycle
        cyc(WR(12'd1, 8'h00), IDLE());
        cyc(WR(12'd1, 8'h01), WR(12'd1, 8'h00));
        rd_r(12'd1, ZEROS, "R6 same-cycle request takes over");
        cyc(IDLE(), WR(12'd1, 8'h01));

        // R8: withdrawal
        cyc(WR(12'd7, 8'h00), IDLE());
        cyc(IDLE(), WR(12'd7, 8'h00));
        cyc(IDLE(), WR(12'd7, 8'h01));
        cyc(WR(12'd7, 8'h01), IDLE());
        rd_r(12'd7, ONES, "R8 withdrawn request not granted");
        rd_l(12'd7, ONES, "R8 sem7 free");

        // R11: write with oe low still writes; no-op cycle
        rd_l(12'd0, ONES, "R11 sem0 free");
        cyc('{sel_n: 1'b0, ce_n: 1'b1, addr: 12'd0, we_n: 1'b0, oe_n: 1'b0, wd: 8'h00}, IDLE());
        push(1'b0, ONES, "R11 write does not load read data");
        cyc('{sel_n: 1'b0, ce_n: 1'b1, addr: 12'd0, we_n: 1'b1, oe_n: 1'b1, wd: 8'h00}, IDLE());
        push(1'b0, ONES, "R11 no read without output enable");
        rd_l(12'd0, ZEROS, "R11 write with oe low took sem0");

        // R10: hold across change
        cyc(WR(12'd0, 8'h01), IDLE());
        push(1'b0, ZEROS, "R10 left data held after release");
        cyc(IDLE(), IDLE());
        push(1'b0, ZEROS, "R10 left data held idle");
        rd_l(12'd0, ONES, "R10 new read shows free");
        rd_r(12'd3, ONES, "R10 right reads sem3");
        cyc(WR(12'd3, 8'h00), IDLE());
        push(1'b1, ONES, "R10 right data held while left claims");
        cyc(WR(12'd3, 8'h01), IDLE());

        // R9: read sees state before a same-cycle write
        cyc(RD(12'd4), WR(12'd4, 8'h00));
        push(1'b0, ONES, "R9 same-cycle read before write");
        cyc(IDLE(), RD(12'd4));
        push(1'b1, ZEROS, "R9 right owns sem4, all bits zero");
        cyc(RD(12'd4), RD(12'd4));
        push(1'b0, ONES, "R9 left view of sem4");
        push(1'b1, ZEROS, "R9 right view of sem4");

        cyc(IDLE(), IDLE());
        cyc(IDLE(), IDLE());
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule